// File: doc/BRIEF.md
# USB Buffer Descriptor Ownership Guard RAM

This block is a 256-byte shared RAM bank holding a table of USB buffer descriptors together with the endpoint data buffers they point to. A CPU port and a USB serial-engine port each read and write it. Every descriptor is a four-byte record. One status bit in that record says which side currently owns the record and the buffer it describes. The block checks every write from either side against that bit and drops any write the owner rule forbids.

A dropped write raises a sticky violation flag. The flag records the address and which side made the write, and stays set until the CPU clears it. Each endpoint has an enable input that covers its two descriptor slots. While an endpoint is disabled, its slots behave as ordinary unprotected RAM. Reads are never gated. The engine hands a descriptor back to the CPU by rewriting the status byte with the ownership bit cleared.

Top module: `usb_bd_guard_ram`

## Requirements
- R1: The bank holds 256 bytes. An accepted write is visible on both read ports from the next clock cycle. The read ports return the addressed byte combinationally.
- R2: Descriptor n occupies bank bytes 4n to 4n+3, holding in order: status, byte count, buffer address low byte, buffer address high byte. Descriptor 2e is the OUT slot and 2e+1 the IN slot of endpoint e. Both slots are active only while ep_enable[e] is 1.
- R3: Bit 7 of the status byte is the ownership bit: 0 means CPU-owned and 1 means engine-owned. The owning side may write the record and its buffer.
- R4: A CPU write to an active engine-owned record, or to the buffer it points to, leaves the bank unchanged.
- R5: An engine write to an active CPU-owned record, or to the buffer it points to, leaves the bank unchanged.
- R6: The protected buffer is the 16-bit address range [start, start+count). The bank sits at addresses 0x0400 to 0x04FF. Only the part of the range inside the bank is protected, and the byte at start+count is open.
- R7: The records of an inactive slot are plain RAM. Writes to them are always accepted, and their fields protect no buffer.
- R8: Both ports read every byte at all times, whatever the ownership.
- R9: A dropped write sets viol_flag in the next cycle. It also captures viol_addr and viol_src (0 = CPU, 1 = engine). The first violation is held until cleared. If both writes are dropped in one cycle, the CPU write is reported. viol_flag is 0 after reset.
- R10: When both ports write the same address in one cycle, the owner's write lands. If both writes are allowed, the CPU write lands.
- R11: An engine write of a status byte with bit 7 clear, to a descriptor the engine owns, is accepted. From then on the CPU owns that descriptor and its buffer.
- R12: A viol_clr pulse clears viol_flag in the next cycle, unless a new dropped write occurs in the same cycle. In that case the new violation is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ep_enable | input | NUM_EP | Per-endpoint descriptor enable |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 8 | CPU bank address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data |
| usb_we | input | 1 | Engine write strobe |
| usb_addr | input | 8 | Engine bank address |
| usb_wdata | input | 8 | Engine write data |
| usb_rdata | output | 8 | Engine read data |
| viol_clr | input | 1 | Clear the violation flag |
| viol_flag | output | 1 | Sticky violation flag |
| viol_addr | output | 8 | Address of the captured violation |
| viol_src | output | 1 | Side of the captured violation |

## Verification
The bench writes one past the end of a protected buffer. A design with an inclusive upper bound would drop that write. It places a buffer that runs past the top of the bank and writes the bottom of the bank. A design whose end address wraps instead of clipping would block it there.

It drives same-address collisions both on an owned buffer and on open RAM. A wrong priority lets the non-owner's byte through, or lets the engine win on open RAM. It exercises hand-back by the engine, the reverse blocking of the engine, and disabled slots. A design that ignored the enables would drop writes there and raise the flag. It also checks that a second violation does not overwrite the first captured address.

// File: rtl/bdg_pkg.sv
package bdg_pkg;
  localparam int BANK_BYTES = 256;
  localparam int AW = 8;

  // Buffer hit: bank byte a (bank based at 'base') lies in [start, start+cnt)
  function automatic logic buf_hit(input logic [AW-1:0] a, input logic [15:0] start,
                                   input logic [7:0] cnt, input logic [15:0] base);
    logic [16:0] full;
    logic [16:0] stop;
    full = {1'b0, base} + {9'd0, a};
    stop = {1'b0, start} + {9'd0, cnt};
    return (full >= {1'b0, start}) && (full < stop);
  endfunction

  // Record hit: bank byte a is one of the four bytes of descriptor d
  function automatic logic rec_hit(input logic [AW-1:0] a, input logic [5:0] d);
    return a[AW-1:2] == d;
  endfunction
endpackage

// File: rtl/bdg_owner_check.sv
module bdg_owner_check
  import bdg_pkg::*;
#(
  parameter int        NDESC     = 32,
  parameter bit        IS_ENGINE = 1'b0,
  parameter logic [15:0] BANK_BASE = 16'h0400
) (
  input  logic [AW-1:0] addr,
  input  logic [NDESC-1:0] desc_act,
  input  logic [NDESC-1:0] desc_own,
  input  logic [NDESC-1:0][15:0] desc_start,
  input  logic [NDESC-1:0][7:0]  desc_cnt,
  output logic blocked
);
  logic [NDESC-1:0] hit;

  for (genvar d = 0; d < NDESC; d++) begin : g_desc
    // foreign: descriptor belongs to the other side
    logic foreign;
    assign foreign = IS_ENGINE ? !desc_own[d] : desc_own[d];
    assign hit[d] = desc_act[d] && foreign &&
                    (rec_hit(addr, 6'(d)) ||
                     buf_hit(addr, desc_start[d], desc_cnt[d], BANK_BASE));
  end

  assign blocked = |hit;
endmodule

// File: rtl/bdg_viol_latch.sv
module bdg_viol_latch
  import bdg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_drop,
  input  logic [AW-1:0] cpu_addr,
  input  logic usb_drop,
  input  logic [AW-1:0] usb_addr,
  input  logic clr,
  output logic flag,
  output logic [AW-1:0] addr_q,
  output logic src_q
);
  logic evt;
  assign evt = cpu_drop || usb_drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      addr_q <= '0;
      src_q  <= 1'b0;
    end else if (evt && (!flag || clr)) begin
      flag   <= 1'b1;
      addr_q <= cpu_drop ? cpu_addr : usb_addr;
      src_q  <= !cpu_drop;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_bd_guard_ram.sv
module usb_bd_guard_ram
  import bdg_pkg::*;
#(
  parameter int          NUM_EP    = 16,
  parameter logic [15:0] BANK_BASE = 16'h0400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] ep_enable,
  input  logic              cpu_we,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic              usb_we,
  input  logic [AW-1:0]     usb_addr,
  input  logic [7:0]        usb_wdata,
  output logic [7:0]        usb_rdata,
  input  logic              viol_clr,
  output logic              viol_flag,
  output logic [AW-1:0]     viol_addr,
  output logic              viol_src
);
  localparam int NDESC = 2 * NUM_EP;

  logic [7:0] mem [BANK_BYTES];

  logic [NDESC-1:0]       desc_act;
  logic [NDESC-1:0]       desc_own;
  logic [NDESC-1:0][15:0] desc_start;
  logic [NDESC-1:0][7:0]  desc_cnt;

  for (genvar d = 0; d < NDESC; d++) begin : g_fields
    assign desc_act[d]   = ep_enable[d/2];
    assign desc_own[d]   = mem[4*d][7];
    assign desc_cnt[d]   = mem[4*d+1];
    assign desc_start[d] = {mem[4*d+3], mem[4*d+2]};
  end

  // Named internal events
  logic cpu_blk, usb_blk;
  logic cpu_commit, usb_commit, cpu_drop, usb_drop;

  bdg_owner_check #(.NDESC(NDESC), .IS_ENGINE(1'b0), .BANK_BASE(BANK_BASE)) u_cpu_chk (
    .addr(cpu_addr), .desc_act(desc_act), .desc_own(desc_own),
    .desc_start(desc_start), .desc_cnt(desc_cnt), .blocked(cpu_blk));

  bdg_owner_check #(.NDESC(NDESC), .IS_ENGINE(1'b1), .BANK_BASE(BANK_BASE)) u_usb_chk (
    .addr(usb_addr), .desc_act(desc_act), .desc_own(desc_own),
    .desc_start(desc_start), .desc_cnt(desc_cnt), .blocked(usb_blk));

  assign cpu_commit = cpu_we && !cpu_blk;
  assign usb_commit = usb_we && !usb_blk;
  assign cpu_drop   = cpu_we && cpu_blk;
  assign usb_drop   = usb_we && usb_blk;

  // Engine first, CPU last: CPU wins when both are allowed on one address
  always_ff @(posedge clk) begin
    if (usb_commit) mem[usb_addr] <= usb_wdata;
    if (cpu_commit) mem[cpu_addr] <= cpu_wdata;
  end

  assign cpu_rdata = mem[cpu_addr];
  assign usb_rdata = mem[usb_addr];

  bdg_viol_latch u_viol (
    .clk(clk), .rst_n(rst_n),
    .cpu_drop(cpu_drop), .cpu_addr(cpu_addr),
    .usb_drop(usb_drop), .usb_addr(usb_addr),
    .clr(viol_clr), .flag(viol_flag), .addr_q(viol_addr), .src_q(viol_src));
endmodule

// File: rtl/bdg_checker.sv
module bdg_checker
  import bdg_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic cpu_we,
  input logic [AW-1:0] cpu_addr,
  input logic [7:0] cpu_wdata,
  input logic usb_we,
  input logic [AW-1:0] usb_addr,
  input logic [7:0] usb_wdata,
  input logic cpu_blk,
  input logic usb_blk,
  input logic viol_clr,
  input logic viol_flag,
  input logic [AW-1:0] viol_addr,
  input logic [7:0] mem [BANK_BYTES]
);
  logic usb_ok_same;
  logic cpu_ok_same;
  assign usb_ok_same = usb_we && !usb_blk && (usb_addr == cpu_addr);
  assign cpu_ok_same = cpu_we && !cpu_blk && (usb_addr == cpu_addr);

  // R4: dropped CPU write leaves the byte untouched
  a_r4_cpu_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_blk && !usb_ok_same) |=> mem[$past(cpu_addr)] == $past(mem[cpu_addr]));

  // R5: dropped engine write leaves the byte untouched
  a_r5_usb_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_we && usb_blk && !cpu_ok_same) |=> mem[$past(usb_addr)] == $past(mem[usb_addr]));

  // R10: both allowed on one address -> CPU data lands
  a_r10_cpu_wins_open: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && !cpu_blk && usb_ok_same) |=> mem[$past(cpu_addr)] == $past(cpu_wdata));

  // R9: a CPU drop on a clear flag is captured with its address
  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_blk && !viol_flag) |=> viol_flag && viol_addr == $past(cpu_addr));

  // R9: flag is sticky without a clear
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !viol_clr) |=> viol_flag && $stable(viol_addr));
endmodule

bind usb_bd_guard_ram bdg_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .usb_we(usb_we), .usb_addr(usb_addr), .usb_wdata(usb_wdata),
  .cpu_blk(cpu_blk), .usb_blk(usb_blk),
  .viol_clr(viol_clr), .viol_flag(viol_flag), .viol_addr(viol_addr),
  .mem(mem));

// File: tb/usb_bd_guard_ram_tb.sv
module usb_bd_guard_ram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_EP = 16;

  logic clk = 0, rst_n = 0;
  logic [NUM_EP-1:0] ep_enable = '0;
  logic cpu_we = 0, usb_we = 0, viol_clr = 0;
  logic [7:0] cpu_addr = 0, cpu_wdata = 0, usb_addr = 0, usb_wdata = 0;
  logic [7:0] cpu_rdata, usb_rdata, viol_addr;
  logic viol_flag, viol_src;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_bd_guard_ram #(.NUM_EP(NUM_EP)) u_dut (
    .clk(clk), .rst_n(rst_n), .ep_enable(ep_enable),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .usb_we(usb_we), .usb_addr(usb_addr), .usb_wdata(usb_wdata), .usb_rdata(usb_rdata),
    .viol_clr(viol_clr), .viol_flag(viol_flag), .viol_addr(viol_addr), .viol_src(viol_src));

  typedef struct { bit eng; logic [7:0] exp; string tag; } item_t;
  item_t q[$];

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected read per cycle, 2 time units after the driver set the address
  always begin
    @(negedge clk); #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(it.tag, {8'd0, it.eng ? usb_rdata : cpu_rdata}, {8'd0, it.exp});
    end
  end

  task automatic rd(input bit eng, input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    if (eng) usb_addr = a; else cpu_addr = a;
    q.push_back('{eng, e, tag});
    @(negedge clk); #3;
  endtask

  task automatic wr(input bit c, input logic [7:0] ca, input logic [7:0] cd,
                    input bit u, input logic [7:0] ua, input logic [7:0] ud);
    @(negedge clk);
    cpu_we = c; cpu_addr = ca; cpu_wdata = cd;
    usb_we = u; usb_addr = ua; usb_wdata = ud;
    @(negedge clk);
    cpu_we = 0; usb_we = 0;
  endtask

  task automatic cw(input logic [7:0] a, input logic [7:0] d); wr(1, a, d, 0, 0, 0); endtask
  task automatic uw(input logic [7:0] a, input logic [7:0] d); wr(0, 0, 0, 1, a, d); endtask

  task automatic clr_flag();
    @(negedge clk); viol_clr = 1;
    @(negedge clk); viol_clr = 0;
  endtask

  task automatic viol(input string tag, input logic f, input logic [7:0] a, input logic s);
    #1;
    check({tag, " flag"}, {15'd0, viol_flag}, {15'd0, f});
    if (f) begin
      check({tag, " addr"}, {8'd0, viol_addr}, {8'd0, a});
      check({tag, " src"}, {15'd0, viol_src}, {15'd0, s});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1; check("R9 reset flag", {15'd0, viol_flag}, 16'd0);
    rst_n = 1;

    // R1/R8 plain RAM
    cw(8'h90, 8'h5A);
    rd(0, 8'h90, 8'h5A, "R1 cpu read");
    rd(1, 8'h90, 8'h5A, "R8 usb read");

    // R2 descriptor 2 (endpoint 1 OUT): buffer 0x0480..0x048F
    cw(8'h08, 8'h00); cw(8'h09, 8'h10); cw(8'h0A, 8'h80); cw(8'h0B, 8'h04);
    cw(8'h85, 8'h11); cw(8'h7F, 8'h00);
    ep_enable[1] = 1'b1;
    cw(8'h08, 8'h80);                       // R3 give to engine
    rd(1, 8'h08, 8'h80, "R3 status owned by engine");
    rd(0, 8'h08, 8'h80, "R8 cpu reads engine-owned status");

    cw(8'h85, 8'hEE);                       // R4 buffer write dropped
    rd(0, 8'h85, 8'h11, "R4 buffer kept");
    viol("R9 first", 1, 8'h85, 0);
    cw(8'h09, 8'hFF);                       // R4 record write dropped
    rd(0, 8'h09, 8'h10, "R4 count kept");
    viol("R9 sticky first addr", 1, 8'h85, 0);

    cw(8'h90, 8'h77);                       // R6 one past end is open
    rd(0, 8'h90, 8'h77, "R6 end exclusive");
    cw(8'h7F, 8'h66);
    rd(0, 8'h7F, 8'h66, "R6 below start open");

    uw(8'h85, 8'hC3);                       // R3 owner writes buffer
    rd(1, 8'h85, 8'hC3, "R3 engine write lands");
    clr_flag();
    viol("R12 cleared", 0, 0, 0);

    wr(1, 8'h86, 8'h01, 1, 8'h86, 8'h02);   // R10 owner wins
    rd(0, 8'h86, 8'h02, "R10 owner wins");
    viol("R9 collision drop", 1, 8'h86, 0);
    clr_flag();

    wr(1, 8'hA0, 8'h33, 1, 8'hA0, 8'h44);   // R10 open RAM -> CPU
    rd(1, 8'hA0, 8'h33, "R10 cpu wins open");

    uw(8'h08, 8'h08);                       // R11 hand back
    rd(0, 8'h08, 8'h08, "R11 handback status");
    cw(8'h85, 8'h99);
    rd(0, 8'h85, 8'h99, "R11 cpu writes after handback");
    viol("R11 no violation", 0, 0, 0);

    uw(8'h85, 8'h55);                       // R5 engine blocked
    rd(1, 8'h85, 8'h99, "R5 engine drop");
    viol("R9 engine source", 1, 8'h85, 1);

    // R12 clear and new violation in the same cycle
    @(negedge clk); viol_clr = 1; usb_we = 1; usb_addr = 8'h84; usb_wdata = 8'h00;
    @(negedge clk); viol_clr = 0; usb_we = 0;
    viol("R12 clear with new drop", 1, 8'h84, 1);
    clr_flag();

    // R7 disabled endpoint 2 (descriptor 4): plain RAM
    cw(8'h10, 8'h80); cw(8'h11, 8'h04); cw(8'h12, 8'hA0); cw(8'h13, 8'h04);
    cw(8'h11, 8'h22);
    rd(0, 8'h11, 8'h22, "R7 disabled record writable");
    cw(8'hA1, 8'h5C);
    rd(0, 8'hA1, 8'h5C, "R7 disabled buffer writable");
    viol("R7 no violation", 0, 0, 0);

    // R6 clipping: descriptor 3, buffer 0x04F0 + 0x20 crosses bank top
    cw(8'h0D, 8'h20); cw(8'h0E, 8'hF0); cw(8'h0F, 8'h04); cw(8'h0C, 8'h80);
    cw(8'hFF, 8'h12);
    viol("R6 top of bank protected", 1, 8'hFF, 0);
    clr_flag();
    cw(8'h00, 8'h3C);
    rd(0, 8'h00, 8'h3C, "R6 no wrap to bank bottom");
    viol("R6 bottom open", 0, 0, 0);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule